// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank synchronous DRAM out of reset into a programmed, usable state. From the release of reset it holds the memory idle for a stabilization pause. The length of the pause in clock cycles comes from the clock frequency and pause-length parameters. During the pause the data mask stays high. The block then closes both banks with a precharge-all command and issues a parameterized number of auto-refresh commands. After that it writes the mode register once, with burst length, burst ordering, CAS latency and operating mode all in the same command. After a short hold it raises a sticky done flag. Every gap between commands is counted in clock cycles and filled with NOP commands.

The control is one Moore state machine. Its named states are ST_PAUSE, ST_PRECH, ST_TRP_WAIT, ST_REFRESH, ST_TRFC_WAIT, ST_MRS, ST_HOLD and ST_DONE. The transitions are:

- ST_PAUSE goes to ST_PRECH when the pause timer runs out.
- ST_PRECH goes to ST_TRP_WAIT unconditionally.
- ST_TRP_WAIT goes to ST_REFRESH when the precharge timer runs out.
- ST_REFRESH goes to ST_TRFC_WAIT unconditionally.
- ST_TRFC_WAIT goes back to ST_REFRESH while refreshes remain, and to ST_MRS after the last one, in both cases when its timer runs out.
- ST_MRS goes to ST_HOLD unconditionally.
- ST_HOLD goes to ST_DONE when the hold timer runs out.
- ST_DONE is terminal.

A single shared down-counter times every wait. The state machine reloads it on each state change. A separate encoder packs and legalizes the mode word from the configuration inputs.

Top module: `sdram_init_seq`

## Requirements
- R1: From the cycle in which reset is released, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111) for exactly PAUSE = CLK_MHZ*PAUSE_US cycles, and also while reset is held.
- R2: DQM is high while reset is held and in every cycle until init_done rises, and it is low from that cycle on.
- R3: The first command after the pause is precharge-all (0010) with address bit 10 high, all other address bits 0 and bank 0. It is followed by exactly TRP_CYC NOP cycles.
- R4: After the precharge gap come exactly NUM_REFRESH (at least 2) auto-refresh commands (0111 → 0001), each followed by exactly TRFC_CYC NOP cycles, with address and bank at 0.
- R5: CKE is low while reset is held and during all pause cycles except the last one. It is high from the last pause cycle onward, so it is high for at least one cycle before the mode register set.
- R6: Right after the last refresh gap, exactly one mode register set (0000) is issued with bank 0. No second mode register set ever follows.
- R7: In the mode register set cycle, all fields are driven together from the configuration inputs: address bits 2:0 = cfg_burst_len, bit 3 = cfg_burst_seq, bits 6:4 = CAS latency, bits ADDR_W-1:7 = cfg_op_mode.
- R8: The CAS latency field is always 1, 2 or 3. A requested 0 is sent as 1, a requested 4 to 7 is sent as 3, and 1 to 3 pass unchanged.
- R9: After the mode register set, exactly MRS_HOLD (at least 2) NOP cycles pass with init_done low. After that, init_done is high and stays high, and only NOPs are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the whole sequence |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_seq | input | 1 | Burst ordering select for the mode word |
| cfg_cas_lat | input | 3 | Requested CAS latency (legalized to 1..3) |
| cfg_op_mode | input | ADDR_W-7 | Operating mode bits for the upper address lines |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_addr | output | ADDR_W | Address lines (precharge-all flag, mode word) |
| sd_ba | output | BA_W | Bank select |
| init_done | output | 1 | Sticky flag: initialization complete |

## Verification
The embedded properties check on every cycle the safety rules that hold at any moment:
- the mask is high whenever CKE is low;
- CKE was high in the cycle before the mode register set;
- the mode register set carries a legal CAS latency;
- the mode register set comes only after the precharge and after the full number of refreshes seen on the pins;
- the two cycles after the mode register set are NOPs with done low;
- done never falls and is followed only by NOPs.

Only the bench's scenarios show the exact cycle positions: the pause length, the precharge and refresh gaps, and the cycle in which done rises. They also show that every mode field, including the clamped latency, matches the configuration for each swept latency and ordering value.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command pin encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECH,
        ST_TRP_WAIT,
        ST_REFRESH,
        ST_TRFC_WAIT,
        ST_MRS,
        ST_HOLD,
        ST_DONE
    } init_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // Once at zero the counter stays there until reloaded
    p_timer_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W = 12,
    localparam int OPW   = ADDR_W - 7
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_seq,
    input  logic [2:0]        cas_lat,
    input  logic [OPW-1:0]    op_mode,
    output logic [ADDR_W-1:0] word
);
    logic [2:0] cl_legal;

    always_comb begin
        if (cas_lat == 3'd0)
            cl_legal = 3'd1;
        else if (cas_lat > 3'd3)
            cl_legal = 3'd3;
        else
            cl_legal = cas_lat;
    end

    assign word = {op_mode, cl_legal, burst_seq, burst_len};

    always_comb begin
        a_cl_range_r8: assert ((cl_legal >= 3'd1) && (cl_legal <= 3'd3));
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int PAUSE_US    = 100,
    parameter int TRP_CYC     = 3,
    parameter int TRFC_CYC    = 9,
    parameter int NUM_REFRESH = 2,
    parameter int MRS_HOLD    = 2,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_burst_len,
    input  logic                cfg_burst_seq,
    input  logic [2:0]          cfg_cas_lat,
    input  logic [ADDR_W-8:0]   cfg_op_mode,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic                sd_cke,
    output logic                sd_dqm,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [BA_W-1:0]     sd_ba,
    output logic                init_done
);
    localparam int PAUSE_CYC = imax(1, CLK_MHZ * PAUSE_US);
    localparam int TRP_EFF   = imax(1, TRP_CYC);
    localparam int TRFC_EFF  = imax(1, TRFC_CYC);
    localparam int NR_EFF    = imax(2, NUM_REFRESH);
    localparam int HOLD_EFF  = imax(2, MRS_HOLD);
    localparam int MAXD      = imax(imax(PAUSE_CYC, TRP_EFF), imax(TRFC_EFF, HOLD_EFF));
    localparam int TW        = $clog2(MAXD + 1);
    localparam int RW        = $clog2(NR_EFF + 1);
    localparam int AP_BIT    = 10;

    init_state_e       state_q, state_d;
    sd_cmd_e           cmd;
    logic [RW-1:0]     ref_q;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic [ADDR_W-1:0] mode_word;

    sdram_init_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
        .burst_len (cfg_burst_len),
        .burst_seq (cfg_burst_seq),
        .cas_lat   (cfg_cas_lat),
        .op_mode   (cfg_op_mode),
        .word      (mode_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSE:     if (tmr_zero) state_d = ST_PRECH;
            ST_PRECH:     state_d = ST_TRP_WAIT;
            ST_TRP_WAIT:  if (tmr_zero) state_d = ST_REFRESH;
            ST_REFRESH:   state_d = ST_TRFC_WAIT;
            ST_TRFC_WAIT: if (tmr_zero)
                              state_d = (ref_q == RW'(NR_EFF)) ? ST_MRS : ST_REFRESH;
            ST_MRS:       state_d = ST_HOLD;
            ST_HOLD:      if (tmr_zero) state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_PAUSE;
        endcase
    end

    // Timer reload on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_TRP_WAIT:  tmr_val = TW'(TRP_EFF - 1);
            ST_TRFC_WAIT: tmr_val = TW'(TRFC_EFF - 1);
            ST_HOLD:      tmr_val = TW'(HOLD_EFF - 1);
            default:      tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_PAUSE;
        else
            state_q <= state_d;
    end

    // Refresh tally
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (state_q == ST_REFRESH)
            ref_q <= ref_q + 1'b1;
    end

    // Output decode
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_ba     = '0;
        sd_cke    = 1'b1;
        sd_dqm    = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            ST_PAUSE:   sd_cke = tmr_zero;
            ST_PRECH: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_REFRESH: cmd = CMD_REF;
            ST_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = mode_word;
            end
            ST_DONE: begin
                sd_dqm    = 1'b0;
                init_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // ---------------- pin-level checking ----------------
    logic [3:0]    pins;
    logic          pre_seen_q;
    logic [RW-1:0] obs_ref_q;

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_seen_q <= 1'b0;
            obs_ref_q  <= '0;
        end else begin
            if (pins == 4'b0010) pre_seen_q <= 1'b1;
            if (pins == 4'b0001 && obs_ref_q != RW'(NR_EFF)) obs_ref_q <= obs_ref_q + 1'b1;
        end
    end

    p_mask_in_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> sd_dqm);

    p_refresh_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0001) |-> pre_seen_q);

    p_refresh_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (obs_ref_q == RW'(NR_EFF)));

    p_cke_before_mrs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> $past(sd_cke));

    p_cl_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (sd_addr[6:4] != 3'd0 && sd_addr[6:4] <= 3'd3));

    p_hold_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |=> (pins == 4'b0111 && !init_done));

    p_hold_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pins == 4'b0000, 2) |-> (pins == 4'b0111 && !init_done));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && pins == 4'b0111));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;
    localparam int CLK_MHZ = 1;
    localparam int PAUSE_US = 100;
    localparam int TRP = 3;
    localparam int TRFC = 5;
    localparam int NR = 3;
    localparam int HOLD = 2;
    localparam int ADDR_W = 12;
    localparam int OPW = ADDR_W - 7;

    localparam int P      = CLK_MHZ * PAUSE_US;
    localparam int N_REF0 = P + 1 + TRP;
    localparam int N_MRS  = N_REF0 + NR * (1 + TRFC);
    localparam int N_DONE = N_MRS + HOLD + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_bl = '0;
    logic cfg_seq = 1'b0;
    logic [2:0] cfg_cl = '0;
    logic [OPW-1:0] cfg_op = '0;
    logic cs_n, ras_n, cas_n, we_n, cke, dqm, done;
    logic [ADDR_W-1:0] addr;
    logic [0:0] ba;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
        .NUM_REFRESH(NR), .MRS_HOLD(HOLD), .ADDR_W(ADDR_W), .BA_W(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_bl), .cfg_burst_seq(cfg_seq),
        .cfg_cas_lat(cfg_cl), .cfg_op_mode(cfg_op),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_cke(cke), .sd_dqm(dqm), .sd_addr(addr), .sd_ba(ba),
        .init_done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clamp_cl(input int cl);
        if (cl == 0) return 1;
        if (cl > 3) return 3;
        return cl;
    endfunction

    task automatic run_case(input int cl, input int seq, input int bl, input int op);
        logic [3:0] pins;
        logic [3:0] e_cmd;
        int e_addr;
        int mw;
        string tag;
        cfg_cl  = 3'(cl);
        cfg_seq = 1'(seq);
        cfg_bl  = 3'(bl);
        cfg_op  = OPW'(op);
        mw = (op << 7) | (clamp_cl(cl) << 4) | (seq << 3) | bl;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        pins = {cs_n, ras_n, cas_n, we_n};
        check(pins == 4'b0111, "R1 reset cmd", pins, 4'b0111);
        check(cke == 1'b0, "R5 reset cke", cke, 0);
        check(dqm == 1'b1, "R2 reset dqm", dqm, 1);
        check(done == 1'b0, "R9 reset done", done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n <= N_DONE + 4; n++) begin
            #1;
            pins = {cs_n, ras_n, cas_n, we_n};
            e_addr = 0;
            if (n < P) begin
                e_cmd = 4'b0111; tag = "R1 pause";
            end else if (n == P) begin
                e_cmd = 4'b0010; tag = "R3 precharge"; e_addr = 1 << 10;
            end else if (n < N_REF0) begin
                e_cmd = 4'b0111; tag = "R3 trp gap";
            end else if (n < N_MRS) begin
                tag = "R4 refresh/trfc";
                e_cmd = (((n - N_REF0) % (1 + TRFC)) == 0) ? 4'b0001 : 4'b0111;
            end else if (n == N_MRS) begin
                e_cmd = 4'b0000; tag = "R6 mode set"; e_addr = mw;
            end else begin
                e_cmd = 4'b0111; tag = "R9 hold/after";
            end
            check(pins == e_cmd, tag, pins, e_cmd);
            if (n == N_MRS) begin
                check(addr == ADDR_W'(mw), "R7 mode word", addr, mw);
                check(int'(addr[6:4]) == clamp_cl(cl), "R8 cas latency", addr[6:4], clamp_cl(cl));
            end else begin
                check(addr == ADDR_W'(e_addr), {tag, " addr"}, addr, e_addr);
            end
            check(ba == 1'b0, {tag, " bank"}, ba, 0);
            check(cke == (n >= P - 1), "R5 cke", cke, (n >= P - 1));
            check(dqm == (n < N_DONE), "R2 dqm", dqm, (n < N_DONE));
            check(done == (n >= N_DONE), "R9 done", done, (n >= N_DONE));
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int cl = 0; cl < 8; cl++) begin
            for (int seq = 0; seq < 2; seq++) begin
                run_case(cl, seq, (cl + 3 * seq) % 8, (cl * 3 + seq * 17) % 32);
            end
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule